// File: doc/BRIEF.md
# Three-Format RISC Instruction Stepper

This block is a small sequential processor core for a fixed 32-bit instruction encoding with three word formats. The top two bits of each word pick the format. One format carries a 30-bit call displacement. One carries a 22-bit field that serves as a branch displacement or as a high-order constant. The third is a three-address register format with an i bit that chooses between a second source register and a 13-bit signed immediate. The core runs add, sub and or, each with register or immediate operands and with flag-setting variants of add and sub. It also runs load-high-constant, PC-relative call, and PC-relative conditional branch with an annul option.

Each instruction takes two cycles. In the first cycle the core presents its PC on a synchronous instruction-memory port. In the second cycle it decodes the word that returns and executes it. Control transfers are delayed through a PC/nPC pair, so the word after a transfer (the delay slot) executes unless the annul rule squashes it. Register writes, the PC pair and the flags are brought out for observation. Memory-format words and any encoding outside the supported subset raise a sticky illegal flag and stop the core until reset.

Top module: `rstep_core`

## Requirements
- R1: While reset is low and right after it, pc_o equals RESET_PC, npc_o equals RESET_PC+4, flags_o is 0, illegal_o is 0 and wr_en is 0.
- R2: An instruction takes two cycles. In the fetch cycle imem_addr equals pc_o, and the word on imem_rdata is consumed in the next cycle. A non-transfer instruction sets pc to the old npc and npc to the old npc plus 4.
- R3: A word with bits [31:30]=10 is a register operation: rd is [29:25], op3 is [24:19], rs1 is [18:14], i is [13] and rs2 is [4:0]. op3 000000 adds, 000100 subtracts (rs1 minus operand) and 000010 ors, and the result is written to rd.
- R4: When i=1 the operand is bits [12:0] sign-extended to 32 bits, covering -4096 to +4095.
- R5: The op3 codes 010000 (add) and 010100 (sub) also set flags_o = {N,Z,V,C}, with V as signed overflow, C as carry out for add and C as unsigned borrow for sub. The codes 000000, 000100 and 000010 leave flags_o unchanged.
- R6: A word with [31:30]=00 and op2 [24:22]=100 writes bits [21:0] into bits [31:10] of rd ([29:25]) and clears bits [9:0].
- R7: Load-high-constant of value>>10 followed by an or-immediate of value & 0x3FF into the same register leaves any 32-bit value in that register.
- R8: Register 0 reads as zero as a source, and a write that targets it leaves wr_en low.
- R9: A word with [31:30]=01 writes its own PC into register 15, moves pc to the old npc and sets npc to PC + (bits [29:0] << 2).
- R10: A word with [31:30]=00 and op2=010 is a branch with annul bit [29] and cond [28:25]: 1000 always, 0000 never, 0001 if Z, 1001 if not Z. When taken, npc becomes PC + (sign-extended [21:0] << 2). When not taken, npc becomes the old npc plus 4. In both cases pc becomes the old npc.
- R11: With the annul bit set, the delay-slot word is squashed (no write, no flag change, pc and npc still advance sequentially) when the condition is always or never, or when a conditional branch is not taken.
- R12: op [31:30]=11, an op3 outside R3 and R5, an op2 other than 010 and 100, and a cond outside R10 all set illegal_o. The core then holds pc_o and npc_o, makes no writes, and stays halted until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| imem_addr | output | 32 | Instruction fetch address (current PC) |
| imem_rdata | input | 32 | Instruction word, valid the cycle after the fetch |
| wr_en | output | 1 | Register write happening this cycle |
| wr_idx | output | 5 | Destination register of the write |
| wr_data | output | 32 | Value written |
| pc_o | output | 32 | Current PC |
| npc_o | output | 32 | Next PC |
| flags_o | output | 4 | Condition flags {N,Z,V,C} |
| illegal_o | output | 1 | Sticky illegal-instruction halt |

## Verification
The assertions check the following on every cycle:
- register 0 never appears as a write target;
- PC and nPC stay word aligned;
- every PC change moves to the previous nPC;
- the illegal halt is sticky, with no writes and a frozen PC.

Other behaviours can only be shown by the bench's instruction sequences, because they depend on what the words mean. These are the arithmetic and flag values, the sign extension of the immediate, constants built from two instructions, the call and branch targets, and which delay slots are squashed. The bench sweeps operand pairs, a range of immediates and every supported branch condition with and without annul.

// File: rtl/rstep_core.sv
module rstep_core #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic        wr_en,
  output logic [4:0]  wr_idx,
  output logic [31:0] wr_data,
  output logic [31:0] pc_o,
  output logic [31:0] npc_o,
  output logic [3:0]  flags_o,
  output logic        illegal_o
);
  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} st_t;

  st_t         st;
  logic [31:0] pc, npc;
  logic [3:0]  flags;
  logic        halted, squash;
  logic [31:0] rf [32];

  wire [31:0] ir    = imem_rdata;
  wire [1:0]  op    = ir[31:30];
  wire [4:0]  rd    = ir[29:25];
  wire [5:0]  op3   = ir[24:19];
  wire [4:0]  rs1   = ir[18:14];
  wire        ibit  = ir[13];
  wire [4:0]  rs2   = ir[4:0];
  wire        abit  = ir[29];
  wire [3:0]  cond  = ir[28:25];
  wire [2:0]  op2   = ir[24:22];
  wire [31:0] simm  = {{19{ir[12]}}, ir[12:0]};

  wire [31:0] src1  = (rs1 == 5'd0) ? 32'h0 : rf[rs1];
  wire [31:0] src2  = ibit ? simm : ((rs2 == 5'd0) ? 32'h0 : rf[rs2]);
  wire [32:0] sum   = {1'b0, src1} + {1'b0, src2};
  wire [32:0] diff  = {1'b0, src1} - {1'b0, src2};

  logic        bad, we, set_cc, taken, uncond, sq_next;
  logic [4:0]  idx;
  logic [31:0] res, nxt_npc;
  logic [3:0]  nflags;

  always_comb begin
    bad     = 1'b0;
    we      = 1'b0;
    set_cc  = 1'b0;
    taken   = 1'b0;
    uncond  = 1'b0;
    sq_next = 1'b0;
    idx     = rd;
    res     = 32'h0;
    nflags  = flags;
    nxt_npc = npc + 32'd4;
    case (op)
      2'b01: begin
        we      = 1'b1;
        idx     = 5'd15;
        res     = pc;
        nxt_npc = pc + {ir[29:0], 2'b00};
      end
      2'b00: begin
        if (op2 == 3'b100) begin
          we  = 1'b1;
          res = {ir[21:0], 10'h0};
        end else if (op2 == 3'b010) begin
          case (cond)
            4'b1000: begin taken = 1'b1;      uncond = 1'b1; end
            4'b0000: begin taken = 1'b0;      uncond = 1'b1; end
            4'b0001: taken = flags[2];
            4'b1001: taken = !flags[2];
            default: bad = 1'b1;
          endcase
          if (taken) nxt_npc = pc + {{8{ir[21]}}, ir[21:0], 2'b00};
          sq_next = abit && (uncond || !taken);
        end else begin
          bad = 1'b1;
        end
      end
      2'b10: begin
        we = 1'b1;
        case (op3)
          6'b000000, 6'b010000: begin
            res    = sum[31:0];
            set_cc = op3[4];
            nflags = {sum[31], sum[31:0] == 32'h0,
                      (src1[31] == src2[31]) && (sum[31] != src1[31]), sum[32]};
          end
          6'b000100, 6'b010100: begin
            res    = diff[31:0];
            set_cc = op3[4];
            nflags = {diff[31], diff[31:0] == 32'h0,
                      (src1[31] != src2[31]) && (diff[31] != src1[31]), diff[32]};
          end
          6'b000010: res = src1 | src2;
          default:   bad = 1'b1;
        endcase
      end
      default: bad = 1'b1;
    endcase
  end

  wire exec = (st == ST_EXEC) && !squash;

  assign wr_en     = exec && !bad && we && (idx != 5'd0);
  assign wr_idx    = idx;
  assign wr_data   = res;
  assign imem_addr = pc;
  assign pc_o      = pc;
  assign npc_o     = npc;
  assign flags_o   = flags;
  assign illegal_o = halted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_FETCH;
      pc     <= RESET_PC;
      npc    <= RESET_PC + 32'd4;
      flags  <= 4'h0;
      halted <= 1'b0;
      squash <= 1'b0;
    end else begin
      case (st)
        ST_FETCH: st <= ST_EXEC;
        ST_EXEC: begin
          if (squash) begin
            squash <= 1'b0;
            pc     <= npc;
            npc    <= npc + 32'd4;
            st     <= ST_FETCH;
          end else if (bad) begin
            halted <= 1'b1;
            st     <= ST_HALT;
          end else begin
            pc     <= npc;
            npc    <= nxt_npc;
            squash <= sq_next;
            if (set_cc) flags <= nflags;
            st     <= ST_FETCH;
          end
        end
        default: st <= ST_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) rf[wr_idx] <= wr_data;
  end
endmodule

// File: rtl/rstep_core_chk.sv
module rstep_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [4:0]  wr_idx,
  input logic [31:0] pc_o,
  input logic [31:0] npc_o,
  input logic        illegal_o
);
  AST_NO_ZERO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != 5'd0)); // R8
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_o[1:0] == 2'b00) && (npc_o[1:0] == 2'b00)); // R9
  AST_PC_FROM_NPC: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_o != $past(pc_o)) |-> (pc_o == $past(npc_o))); // R2
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |=> (illegal_o && $stable(pc_o) && $stable(npc_o))); // R12
  AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !wr_en); // R12
endmodule

bind rstep_core rstep_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
  .pc_o(pc_o), .npc_o(npc_o), .illegal_o(illegal_o)
);

// File: tb/rstep_core_test.sv
module rstep_core_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata = 32'h0, wr_data, pc_o, npc_o;
  logic        wr_en, illegal_o;
  logic [4:0]  wr_idx;
  logic [3:0]  flags_o;

  rstep_core uut (.clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .pc_o(pc_o), .npc_o(npc_o),
    .flags_o(flags_o), .illegal_o(illegal_o));

  always #2 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_pc, m_npc;
  logic [3:0]  m_fl;
  logic        s_we, s_ill;
  logic [4:0]  s_idx;
  logic [31:0] s_data, s_pc, s_npc;
  logic [3:0]  s_fl;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] f3r(input logic [5:0] o3, input logic [4:0] d, input logic [4:0] a, input logic [4:0] b);
    return {2'b10, d, o3, a, 1'b0, 8'h0, b};
  endfunction
  function automatic logic [31:0] f3i(input logic [5:0] o3, input logic [4:0] d, input logic [4:0] a, input logic [12:0] k);
    return {2'b10, d, o3, a, 1'b1, k};
  endfunction
  function automatic logic [31:0] sethi(input logic [4:0] d, input logic [21:0] k);
    return {2'b00, d, 3'b100, k};
  endfunction
  function automatic logic [31:0] br(input logic a, input logic [3:0] c, input logic [21:0] d);
    return {2'b00, a, c, 3'b010, d};
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(pc_o == 32'h0 && npc_o == 32'h4, "R1 pc/npc", pc_o, 32'h0);
    chk(flags_o == 4'h0 && !illegal_o && !wr_en, "R1 flags/illegal/wr", {27'h0, wr_en, flags_o}, 32'h0);
    rst_n = 1'b1;
    m_pc = 32'h0; m_npc = 32'h4; m_fl = 4'h0;
  endtask

  task automatic step(input logic [31:0] ins);
    chk(imem_addr == m_pc, "R2 fetch address", imem_addr, m_pc);
    imem_rdata = ins;
    @(posedge clk); @(negedge clk);
    s_we = wr_en; s_idx = wr_idx; s_data = wr_data;
    @(posedge clk); @(negedge clk);
    s_pc = pc_o; s_npc = npc_o; s_fl = flags_o; s_ill = illegal_o;
  endtask

  task automatic seq();
    m_pc = m_npc; m_npc = m_npc + 32'd4;
  endtask

  task automatic chk_pc(input string req);
    chk(s_pc == m_pc && s_npc == m_npc, req, s_pc ^ s_npc, m_pc ^ m_npc);
  endtask

  task automatic chk_wr(input string req, input logic [4:0] d, input logic [31:0] v);
    chk(s_we && s_idx == d && s_data == v, req, s_data, v);
  endtask

  task automatic ldc(input logic [4:0] d, input logic [31:0] v);
    step(sethi(d, v[31:10]));
    chk_wr("R6 sethi", d, {v[31:10], 10'h0}); seq(); chk_pc("R2 seq");
    step(f3i(6'b000010, d, d, {3'b000, v[9:0]}));
    chk_wr("R7 constant", d, v); seq(); chk_pc("R2 seq");
  endtask

  logic [31:0] vals [6] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'h30cf0034};

  initial begin
    do_reset();
    ldc(5'd8, 32'h30cf0034);

    for (int i = 0; i < 6; i++) begin
      for (int j = 0; j < 6; j++) begin
        logic [31:0] a, b, r;
        logic [32:0] w;
        a = vals[i]; b = vals[j];
        ldc(5'd1, a); ldc(5'd2, b);
        w = {1'b0, a} + {1'b0, b}; r = w[31:0];
        step(f3r(6'b010000, 5'd3, 5'd1, 5'd2));
        m_fl = {r[31], r == 0, (a[31] == b[31]) && (r[31] != a[31]), w[32]};
        chk_wr("R3 addcc", 5'd3, r); chk(s_fl == m_fl, "R5 addcc flags", {28'h0, s_fl}, {28'h0, m_fl});
        seq();
        r = a - b;
        step(f3r(6'b010100, 5'd4, 5'd1, 5'd2));
        m_fl = {r[31], r == 0, (a[31] != b[31]) && (r[31] != a[31]), a < b};
        chk_wr("R3 subcc", 5'd4, r); chk(s_fl == m_fl, "R5 subcc flags", {28'h0, s_fl}, {28'h0, m_fl});
        seq();
        step(f3r(6'b000010, 5'd5, 5'd1, 5'd2));
        chk_wr("R3 or", 5'd5, a | b); seq();
        step(f3r(6'b000000, 5'd6, 5'd2, 5'd1));
        chk_wr("R3 add", 5'd6, a + b); chk(s_fl == m_fl, "R5 add keeps flags", {28'h0, s_fl}, {28'h0, m_fl}); seq();
        step(f3r(6'b000100, 5'd7, 5'd2, 5'd1));
        chk_wr("R3 sub", 5'd7, b - a); chk(s_fl == m_fl, "R5 sub keeps flags", {28'h0, s_fl}, {28'h0, m_fl}); seq();
        chk_pc("R2 seq");
      end
    end

    for (int k = -4096; k <= 4095; k += 127) begin
      logic [31:0] e;
      e = k;
      step(f3i(6'b000000, 5'd9, 5'd0, e[12:0]));
      chk_wr("R4 imm add", 5'd9, e); seq();
      step(f3i(6'b000100, 5'd10, 5'd0, e[12:0]));
      chk_wr("R4 imm sub", 5'd10, -e); seq();
    end
    step(f3i(6'b000000, 5'd9, 5'd0, 13'h0FFF));
    chk_wr("R4 imm max", 5'd9, 32'd4095); seq();
    step(f3i(6'b000000, 5'd9, 5'd0, 13'h1000));
    chk_wr("R4 imm min", 5'd9, 32'hFFFFF000); seq();

    ldc(5'd1, 32'h12345678);
    step(f3i(6'b000000, 5'd0, 5'd1, 13'd5));
    chk(!s_we, "R8 write to r0 suppressed", {31'h0, s_we}, 32'h0); seq();
    step(f3r(6'b000010, 5'd11, 5'd0, 5'd0));
    chk_wr("R8 r0 reads zero", 5'd11, 32'h0); seq();

    begin
      logic [31:0] p;
      p = m_pc;
      step({2'b01, 30'h100});
      chk_wr("R9 call link", 5'd15, p);
      m_pc = m_npc; m_npc = p + 32'h400; chk_pc("R9 call target");
      step(f3i(6'b000000, 5'd12, 5'd0, 13'd3));
      chk_wr("R9 delay slot runs", 5'd12, 32'd3); seq(); chk_pc("R9 lands on target");
      p = m_pc;
      step({2'b01, 30'h3FFFFFFE});
      chk_wr("R9 call link back", 5'd15, p);
      m_pc = m_npc; m_npc = p - 32'd8; chk_pc("R9 negative target");
      step(f3i(6'b000000, 5'd12, 5'd0, 13'd4)); seq(); chk_pc("R9 lands");
    end

    // Z=1 via addcc to r0 (no write), then branch cases
    step(f3i(6'b010000, 5'd0, 5'd0, 13'd0));
    m_fl = 4'b0100; chk(s_fl == m_fl && !s_we, "R5 Z set", {27'h0, s_we, s_fl}, {28'h0, m_fl}); seq();
    for (int c = 0; c < 4; c++) begin
      for (int an = 0; an < 2; an++) begin
        for (int z = 0; z < 2; z++) begin
          logic [3:0] cc;
          logic tk, un, sq;
          logic [31:0] p, tgt;
          cc = (c == 0) ? 4'b1000 : (c == 1) ? 4'b0000 : (c == 2) ? 4'b0001 : 4'b1001;
          if (z == 1) begin
            step(f3i(6'b010000, 5'd0, 5'd0, 13'd0)); m_fl = 4'b0100; seq();
          end else begin
            step(f3i(6'b010000, 5'd0, 5'd0, 13'd1)); m_fl = 4'b0000; seq();
          end
          un = (c < 2);
          tk = (c == 0) || (c == 2 && z == 1) || (c == 3 && z == 0);
          sq = (an == 1) && (un || !tk);
          p = m_pc;
          tgt = (c[0]) ? p - 32'd12 : p + 32'd20;
          step(br(an[0], cc, c[0] ? 22'h3FFFFD : 22'd5));
          chk(!s_we, "R10 branch writes nothing", {31'h0, s_we}, 32'h0);
          m_pc = m_npc; m_npc = tk ? tgt : m_npc + 32'd4;
          chk_pc("R10 branch next pc");
          step(f3i(6'b010000, 5'd13, 5'd0, 13'd7));
          if (sq) begin
            chk(!s_we && s_fl == m_fl, "R11 delay slot squashed", {27'h0, s_we, s_fl}, {28'h0, m_fl});
          end else begin
            chk_wr("R11 delay slot runs", 5'd13, 32'd7); m_fl = 4'b0000;
          end
          seq(); chk_pc("R11 pc after slot");
        end
      end
    end

    step({2'b11, 30'h0});
    chk(s_ill && !s_we && s_pc == m_pc && s_npc == m_npc, "R12 memory op halts", {31'h0, s_ill}, 32'h1);
    repeat (6) @(negedge clk);
    chk(illegal_o && pc_o == m_pc && !wr_en, "R12 halt sticky", pc_o, m_pc);
    do_reset();
    step(f3r(6'b000001, 5'd1, 5'd0, 5'd0));
    chk(s_ill && !s_we, "R12 bad op3", {31'h0, s_ill}, 32'h1);
    do_reset();
    step({2'b00, 5'd1, 3'b000, 22'h0});
    chk(s_ill && !s_we, "R12 bad op2", {31'h0, s_ill}, 32'h1);
    do_reset();
    step(br(1'b0, 4'b0010, 22'd1));
    chk(s_ill && s_pc == 32'h0, "R12 bad cond", {31'h0, s_ill}, 32'h1);
    do_reset();
    step(f3i(6'b000000, 5'd1, 5'd0, 13'd9));
    chk_wr("R12 runs after reset", 5'd1, 32'd9);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule